// File: doc/BRIEF.md
# Frobenius-Class Canonical Point Selector

This block takes an elliptic-curve point over GF(2^M) whose coordinates are already in normal-basis form and returns the single representative of its Frobenius equivalence class. In this representation every squaring of a coordinate is a cyclic rotation. All M powers x^(2^i) are therefore available by fixed wiring, with no field squarer. A pipelined binary tree of comparators picks the rotation whose x value, read as an unsigned integer, is smallest. The y coordinate is then rotated by the same amount. The winning rotation count is also output, so that the caller can update the scalar pair that goes with the point.

The block sits inside a random-walk iteration pipeline and accepts one point per cycle. Both sides use a valid/ready handshake. A beat moves on a side when valid and ready are both high at a rising clock edge. Back-pressure is global: when the output holds a beat that is not taken, the whole pipeline freezes, and `in_rdy` drops in that same cycle. The output beat stays stable until it is accepted. Points are never dropped or reordered.

Comparison may be narrowed to the top `TB` bits of each candidate to save comparator area. Candidates that tie within those bits are resolved towards the lowest rotation count. With narrowing, the choice can differ from the true minimum, and the surrounding algorithm accepts that.

Top module: `cps_canon_sel`

## Requirements
- R1: With `TB` = M, `out_x` equals the left rotation of `in_x` by the count i in 0..M-1 that gives the smallest unsigned value. A left rotation by i moves bit k to bit (k+i) mod M, which is x^(2^i) in normal basis.
- R2: `out_rot` carries the winning count i, which is always below M. When several counts give equal compared values, the lowest count wins. An all-zero or all-one x gives count 0.
- R3: `out_y` equals `in_y` rotated left by the same count that `out_rot` reports.
- R4: With `out_rdy` held high, a beat accepted at rising edge n appears on `out_vld` after edge n+LAT, where LAT = ceil(log2 M) + 1 (8 for M = 113).
- R5: `in_rdy` is high whenever `out_vld` is low or `out_rdy` is high, so a new point is accepted on every cycle when the output is not stalled.
- R6: While `out_vld` is high and `out_rdy` is low, `out_vld`, `out_x`, `out_y` and `out_rot` hold their values. Every accepted beat leaves exactly once, in the order it arrived.
- R7: After reset, `out_vld` is low and `in_rdy` is high.
- R8: With `TB` < M, only the top `TB` bits (bits M-1 down to M-TB) of each rotated x are compared. A tie within those bits goes to the lowest rotation count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input point valid |
| in_rdy | output | 1 | Pipeline can take a point this cycle |
| in_x | input | M | x coordinate, normal basis |
| in_y | input | M | y coordinate, normal basis |
| out_vld | output | 1 | Output point valid |
| out_rdy | input | 1 | Downstream takes the output point |
| out_x | output | M | Canonical x (minimal rotation) |
| out_y | output | M | y rotated by the same count |
| out_rot | output | ceil(log2 M) | Winning rotation count |

## Verification
The full-width instance is fed an all-zero and an all-one x, where every rotation ties and the lowest count must win. It also gets an x with a single set bit at each of the 113 positions, which pins down the rotation direction and the mapping from a leaf to its count. A second instance with M = 7 and a 3-bit compare window is swept over all 128 x values; the narrow window makes ties common, which shows that the lowest-count rule holds on truncated keys. Random points are run twice, once at full rate with the output always ready (this measures latency and throughput) and once with a random ready signal (this shows that stalled output beats hold and that no beat is lost or duplicated).

// File: rtl/cps_rotl.sv
module cps_rotl #(
  parameter int W  = 113,
  parameter int AW = 7
) (
  input  logic [W-1:0]  d,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  q
);
  // left rotation: bit k lands on bit (k+amt) mod W, for amt < W
  logic [2*W-1:0] dbl;
  assign dbl = {d, d} << amt;
  assign q   = dbl[2*W-1:W];
endmodule

// File: rtl/cps_cmp_node.sv
module cps_cmp_node #(
  parameter int KW = 113,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [KW-1:0] a_key,
  input  logic [IW-1:0] a_idx,
  input  logic [KW-1:0] b_key,
  input  logic [IW-1:0] b_idx,
  output logic [KW-1:0] o_key,
  output logic [IW-1:0] o_idx
);
  // a always holds the lower rotation counts, so b only wins when strictly smaller
  always_ff @(posedge clk) begin
    if (en) begin
      if (b_key < a_key) begin
        o_key <= b_key;
        o_idx <= b_idx;
      end else begin
        o_key <= a_key;
        o_idx <= a_idx;
      end
    end
  end

  AST_NODE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (o_key <= $past(a_key)) && (o_key <= $past(b_key))); // R1
  AST_NODE_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en && (a_key == b_key) |=> (o_idx == $past(a_idx))); // R2
endmodule

// File: rtl/cps_min_tree.sv
module cps_min_tree #(
  parameter int M      = 113,
  parameter int TB     = 113,
  parameter int LEVELS = 7,
  parameter int IW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [M-1:0]  x,
  output logic [TB-1:0] root_key,
  output logic [IW-1:0] root_idx
);
  localparam int P = 1 << LEVELS;  // leaves, padded to a power of two

  logic [TB-1:0] leaf_key [P];
  logic [IW-1:0] leaf_idx [P];
  logic [TB-1:0] node_key [P-1];
  logic [IW-1:0] node_idx [P-1];

  // leaves: every rotation of x by fixed wiring; pad leaves sit to the right and lose ties
  for (genvar i = 0; i < P; i++) begin : g_leaf
    assign leaf_idx[i] = IW'(i);
    if (i < M) begin : g_real
      logic [M-1:0] rx;
      cps_rotl #(.W(M), .AW(IW)) u_rot (.d(x), .amt(IW'(i)), .q(rx));
      assign leaf_key[i] = rx[M-1 -: TB];
    end else begin : g_pad
      assign leaf_key[i] = '1;
    end
  end

  // heap layout: node j has children 2j+1 and 2j+2; indices >= P-1 are leaves
  for (genvar j = 0; j < P - 1; j++) begin : g_node
    localparam int L = 2 * j + 1;
    if (L >= P - 1) begin : g_bottom
      cps_cmp_node #(.KW(TB), .IW(IW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .en(en),
        .a_key(leaf_key[L-(P-1)]),   .a_idx(leaf_idx[L-(P-1)]),
        .b_key(leaf_key[L+1-(P-1)]), .b_idx(leaf_idx[L+1-(P-1)]),
        .o_key(node_key[j]), .o_idx(node_idx[j]));
    end else begin : g_inner
      cps_cmp_node #(.KW(TB), .IW(IW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .en(en),
        .a_key(node_key[L]),   .a_idx(node_idx[L]),
        .b_key(node_key[L+1]), .b_idx(node_idx[L+1]),
        .o_key(node_key[j]), .o_idx(node_idx[j]));
    end
  end

  assign root_key = node_key[0];
  assign root_idx = node_idx[0];
endmodule

// File: rtl/cps_pipe.sv
module cps_pipe #(
  parameter int W = 1,
  parameter int D = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [D+1];
  assign stg[0] = d;

  for (genvar s = 1; s <= D; s++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stg[s] <= '0;
      else if (en) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[D];
endmodule

// File: rtl/cps_canon_sel.sv
module cps_canon_sel #(
  parameter int M      = 113,
  parameter int TB     = M,
  localparam int LEVELS = $clog2(M),
  localparam int IW     = LEVELS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  output logic          in_rdy,
  input  logic [M-1:0]  in_x,
  input  logic [M-1:0]  in_y,
  output logic          out_vld,
  input  logic          out_rdy,
  output logic [M-1:0]  out_x,
  output logic [M-1:0]  out_y,
  output logic [IW-1:0] out_rot
);
  // global advance: freeze everything while an output beat waits
  logic en;
  assign en     = out_rdy || !out_vld;
  assign in_rdy = en;

  logic          vld_d;
  logic [M-1:0]  x_d, y_d;
  logic [TB-1:0] win_key;
  logic [IW-1:0] win_idx;

  cps_min_tree #(.M(M), .TB(TB), .LEVELS(LEVELS), .IW(IW)) u_tree (
    .clk(clk), .rst_n(rst_n), .en(en), .x(in_x),
    .root_key(win_key), .root_idx(win_idx));

  cps_pipe #(.W(1), .D(LEVELS)) u_vpipe (
    .clk(clk), .rst_n(rst_n), .en(en), .d(in_vld && in_rdy), .q(vld_d));

  // x and y wait beside the tree; only key bits and the count ride through it
  cps_pipe #(.W(2*M), .D(LEVELS)) u_xypipe (
    .clk(clk), .rst_n(rst_n), .en(en), .d({in_x, in_y}), .q({x_d, y_d}));

  logic [M-1:0] x_rot, y_rot;
  cps_rotl #(.W(M), .AW(IW)) u_xrot (.d(x_d), .amt(win_idx), .q(x_rot));
  cps_rotl #(.W(M), .AW(IW)) u_yrot (.d(y_d), .amt(win_idx), .q(y_rot));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_x   <= '0;
      out_y   <= '0;
      out_rot <= '0;
    end else if (en) begin
      out_vld <= vld_d;
      out_x   <= x_rot;
      out_y   <= y_rot;
      out_rot <= win_idx;
    end
  end

  // win_key is consumed only by the check below
  AST_KEY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    en && vld_d |=> out_x[M-1 -: TB] == $past(win_key)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_rdy |=> out_vld && $stable(out_x) && $stable(out_y) && $stable(out_rot)); // R6
  AST_ROT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> int'(out_rot) < M); // R2
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> in_rdy); // R5
endmodule

// File: tb/tb_cps_canon_sel.sv
module tb_cps_canon_sel;
  localparam int M  = 113;
  localparam int SM = 7;
  localparam int ST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         in_vld = 1'b0, in_rdy, out_vld, out_rdy = 1'b1;
  logic [M-1:0] in_x = '0, in_y = '0, out_x, out_y;
  logic [6:0]   out_rot;

  logic          t_in_vld = 1'b0, t_in_rdy, t_out_vld;
  logic [SM-1:0] t_in_x = '0, t_in_y = '0, t_out_x, t_out_y;
  logic [2:0]    t_out_rot;

  cps_canon_sel #(.M(M)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy), .in_x(in_x), .in_y(in_y),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_x(out_x), .out_y(out_y), .out_rot(out_rot));

  cps_canon_sel #(.M(SM), .TB(ST)) dut_t (
    .clk(clk), .rst_n(rst_n), .in_vld(t_in_vld), .in_rdy(t_in_rdy), .in_x(t_in_x), .in_y(t_in_y),
    .out_vld(t_out_vld), .out_rdy(1'b1), .out_x(t_out_x), .out_y(t_out_y), .out_rot(t_out_rot));

  typedef struct {
    logic [M-1:0] x;
    logic [M-1:0] y;
    int           r;
    int           cyc;
    bit           lat;
  } exp_t;

  exp_t q_main[$];
  exp_t q_small[$];
  int unsigned n_tot = 0, n_fail = 0;
  int cyc = 0;
  bit rdy_mode = 1'b0;
  int ti = 0;
  bit hold_pend = 1'b0;
  logic [M-1:0] hx, hy;
  logic [6:0] hr;

  task automatic chk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [M-1:0] rot(input logic [M-1:0] x, input int i, input int m);
    logic [M-1:0] r = '0;
    for (int k = 0; k < m; k++) r[(k + i) % m] = x[k];
    return r;
  endfunction

  // scan every rotation; key is the top tb bits; strict less keeps the lowest count
  function automatic int best_rot(input logic [M-1:0] x, input int m, input int tb);
    logic [M-1:0] bk = '0;
    int bi = 0;
    for (int i = 0; i < m; i++) begin
      logic [M-1:0] key;
      key = rot(x, i, m) >> (m - tb);
      if (i == 0 || key < bk) begin
        bk = key;
        bi = i;
      end
    end
    return bi;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  endtask

  task automatic step(input bit vld, input logic [M-1:0] x, input logic [M-1:0] y, output bit took);
    exp_t e;
    @(negedge clk);
    cyc++;
    if (hold_pend) begin
      chk(out_vld && out_x == hx && out_y == hy && out_rot == hr, "R6 hold", out_x, hx);
    end
    out_rdy = rdy_mode ? 1'($urandom % 2) : 1'b1;
    in_vld = vld; in_x = x; in_y = y;
    if (ti < 128) begin
      t_in_vld = 1'b1; t_in_x = SM'(ti); t_in_y = SM'($urandom);
    end else t_in_vld = 1'b0;
    #1;
    if (out_vld && out_rdy) begin
      if (q_main.size() == 0) chk(1'b0, "R6 extra beat", out_x, '0);
      else begin
        e = q_main.pop_front();
        chk(out_x == e.x, "R1 x", out_x, e.x);
        chk(int'(out_rot) == e.r, "R2 rot", M'(out_rot), M'(e.r));
        chk(out_y == e.y, "R3 y", out_y, e.y);
        if (e.lat && rdy_mode == 1'b0) chk(cyc - e.cyc == 8, "R4 latency", M'(cyc - e.cyc), M'(8));
      end
    end
    hold_pend = out_vld && !out_rdy;
    hx = out_x; hy = out_y; hr = out_rot;
    if (t_out_vld) begin
      if (q_small.size() == 0) chk(1'b0, "R8 extra beat", M'(t_out_x), '0);
      else begin
        e = q_small.pop_front();
        chk(M'(t_out_x) == e.x, "R8 x", M'(t_out_x), e.x);
        chk(int'(t_out_rot) == e.r, "R8 rot", M'(t_out_rot), M'(e.r));
        chk(M'(t_out_y) == e.y, "R8 y", M'(t_out_y), e.y);
      end
    end
    took = in_vld && in_rdy;
    if (took) begin
      e.r = best_rot(x, M, M);
      e.x = rot(x, e.r, M); e.y = rot(y, e.r, M);
      e.cyc = cyc; e.lat = !rdy_mode;
      q_main.push_back(e);
    end
    if (t_in_vld) begin
      e.r = best_rot(M'(t_in_x), SM, ST);
      e.x = rot(M'(t_in_x), e.r, SM); e.y = rot(M'(t_in_y), e.r, SM);
      e.cyc = cyc; e.lat = 1'b0;
      q_small.push_back(e);
      ti++;
    end
  endtask

  task automatic send(input logic [M-1:0] x, input logic [M-1:0] y);
    bit took = 1'b0;
    int tries = 0;
    while (!took) begin
      step(1'b1, x, y, took);
      tries++;
    end
    if (!rdy_mode) chk(tries == 1, "R5 full rate", M'(tries), M'(1));
  endtask

  task automatic idle(input int n);
    bit took;
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, took);
  endtask

  function automatic logic [M-1:0] rnd();
    return M'({$urandom, $urandom, $urandom, $urandom});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_vld, "R7 out_vld", M'(out_vld), '0);
    chk(in_rdy, "R7 in_rdy", M'(in_rdy), M'(1));
    chk(!t_out_vld, "R7 small out_vld", M'(t_out_vld), '0);

    // single beat alone: latency R4
    send(rnd(), rnd());
    idle(12);
    // ties everywhere: lowest count R2
    send('0, rnd());
    send('1, rnd());
    // single bit: x = 1<<5 must rotate by 108 so the bit lands on bit 0 (R1)
    for (int k = 0; k < M; k++) send(M'(1) << k, rnd());
    for (int k = 0; k < 40; k++) send((M'(1) << k) | (M'(1) << (k + 50)), rnd());
    // random at full rate
    for (int i = 0; i < 300; i++) send(rnd(), rnd());
    idle(12);
    // random with back-pressure: R6
    rdy_mode = 1'b1;
    for (int i = 0; i < 300; i++) send(rnd(), rnd());
    rdy_mode = 1'b0;
    idle(20);
    while (ti < 128) idle(1);
    idle(12);
    chk(q_main.size() == 0, "R6 all beats out", M'(q_main.size()), '0);
    chk(q_small.size() == 0, "R8 all beats out", M'(q_small.size()), '0);
    finish_run();
  end
endmodule